// File: doc/BRIEF.md
# Vectored Interrupt Pending/Service Controller

This block collects up to 64 interrupt inputs and turns their activity into a stream of set and clear events for a downstream distributor. Each source has a request bit, an in-service bit, a mask bit, an edge-select bit and an 8-bit output vector that software may remap. A source that asserts while unmasked becomes in service and produces a set event carrying its vector. A source that leaves service produces a clear event. Level sources leave service when the input drops. Edge sources ignore the input dropping and leave service only through a write-one-to-clear register.

Software reaches the block through a simple request/acknowledge register port with 64-bit words and 1, 2, 4 or 8 byte accesses. A write that changes several mask or clear bits schedules work for every affected source. A scanner then handles the pending sources one per cycle, in ascending index order. Events leave through a valid/ready handshake, at most one per cycle. The register port does not acknowledge the next access until all pending work and the output slot are empty. Polarity, route and auto-control words exist only so that software finds them. They change no behaviour.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the mask word (offset 0x008) reads all ones. The request (0x028), in-service (0x030), edge-select (0x010) and polarity (0x020) words read zero. Byte i of the vector table at 0x200 reads i. Every byte of the route table at 0x100 reads 0x01. No event is valid.
- R2: A rising input sets the source's request bit. If the source's mask bit is 0, the in-service bit is also set and a set event (evt_level = 1) with the source's vector is emitted.
- R3: A falling input on a level source (edge-select bit 0) clears its request bit. If its in-service bit is set, the in-service bit is cleared and a clear event (evt_level = 0) with its vector is emitted.
- R4: A falling input on an edge source (edge-select bit 1) is ignored. Request and in-service stay set and no event is emitted.
- R5: A write to the edge-clear word (0x018) clears the request bits in data AND edge-select AND request. Each cleared source that was in service leaves service with a clear event.
- R6: A mask write merges the written bytes. Every bit going 1→0 runs the assert path of R2. Every bit going 0→1 runs the leave-service check of R3, which emits nothing while that source's request is still set.
- R7: Sources affected by a single change are handled in ascending index order with at most one event per cycle. An event holds its vector and level stable while evt_ready is low.
- R8: bus_size 0, 1, 2, 3 selects 1, 2, 4, 8 bytes. A write changes only byte lanes off to off+len-1, where off = bus_addr[2:0]. Read data is the addressed 64-bit word shifted right by 8×off bits.
- R9: bus_err is raised with the acknowledge, and no state changes, for any of these accesses: an address not aligned to its length, an unmapped word, a write to the ID word, or a read of the edge-clear word.
- R10: Writes to the request and in-service words, the route table and the auto-control words (0x038, 0x040) are acknowledged without error and change nothing. The auto-control words read zero.
- R11: The ID word at 0x000 carries ID_CODE in bits 31:24, ID_VER in bits 39:32 and NSRC-1 in bits 55:48. All other bits are zero.
- R12: A mask or edge-clear write is acknowledged only after every event it caused has been accepted. No access starts while work is pending.
- R13: Vector table bytes are writable, and later events for that source carry the written vector.
- R14: The polarity word stores and returns written data, and has no effect on how inputs are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NSRC | Interrupt inputs, high = asserted |
| bus_req | input | 1 | Register access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address within the block |
| bus_size | input | 2 | Access size code, bytes = 1 << bus_size |
| bus_wdata | input | 64 | Write data, right-aligned |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_err | output | 1 | Access rejected, valid with bus_ack |
| bus_rdata | output | 64 | Read data, valid with bus_ack |
| evt_valid | output | 1 | Downstream event valid |
| evt_ready | input | 1 | Downstream accepts the event |
| evt_vec | output | 8 | Vector of the event |
| evt_level | output | 1 | 1 = set, 0 = clear |

## Verification
The event path is tried with single level sources rising and falling, and with an edge source whose falling input must produce nothing until the clear word is written. Three simultaneous rises with a toggling ready line show whether the scan order is ascending and whether a stalled event stays put. Masked requests that are later unmasked and then masked again separate the assert path from the leave-service check. A remapped vector shows that events read the table rather than the index. Byte-lane writes, offset reads and misaligned or unmapped accesses separate correct lane merging from whole-word updates and from silent acceptance.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE  = 1'b0,
        BUS_DRAIN = 1'b1
    } bus_st_e;

    // word byte offsets
    localparam int ADR_ID    = 'h000;
    localparam int ADR_MASK  = 'h008;
    localparam int ADR_EDGE  = 'h010;
    localparam int ADR_ECLR  = 'h018;
    localparam int ADR_POL   = 'h020;
    localparam int ADR_REQ   = 'h028;
    localparam int ADR_INSVC = 'h030;
    localparam int ADR_AUTO0 = 'h038;
    localparam int ADR_AUTO1 = 'h040;
    localparam int ADR_ROUTE = 'h100;
    localparam int ADR_VEC   = 'h200;

    localparam logic [7:0] ROUTE_BYTE = 8'h01;

endpackage

// File: rtl/irq_vec_lanes.sv
module irq_vec_lanes #(
    parameter int DW = 64
) (
    input  logic [2:0]    off,
    input  logic [1:0]    size,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] wmask,
    output logic [DW-1:0] wsh,
    output logic          misal
);
    localparam int NB = DW / 8;

    logic [2:0]    len_m1;
    logic [NB-1:0] be_base;
    logic [NB-1:0] be;

    always_comb begin
        case (size)
            2'd0:    len_m1 = 3'd0;
            2'd1:    len_m1 = 3'd1;
            2'd2:    len_m1 = 3'd3;
            default: len_m1 = 3'd7;
        endcase
        misal   = |(off & len_m1);
        be_base = {NB{1'b1}} >> (3'd7 - len_m1);
        be      = be_base << off;
        wsh     = wdata << {off, 3'b000};
    end

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign wmask[8*b +: 8] = {8{be[b]}};
    end

endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick #(
    parameter int N  = 64,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_vec_evtq.sv
module irq_vec_evtq #(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] load_vec,
    input  logic          load_lvl,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [VW-1:0] out_vec,
    output logic          out_lvl,
    output logic          room
);
    typedef struct packed {
        logic          v;
        logic [VW-1:0] vec;
        logic          lvl;
    } slot_t;

    slot_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (out_ready) q_d.v = 1'b0;
        if (load) begin
            q_d.v   = 1'b1;
            q_d.vec = load_vec;
            q_d.lvl = load_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign room      = !q_q.v || out_ready;
    assign out_valid = q_q.v;
    assign out_vec   = q_q.vec;
    assign out_lvl   = q_q.lvl;

    // R7
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vec) && $stable(out_lvl)));

    // R7
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!out_valid || out_ready));

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int         NSRC    = 64,
    parameter int         AW      = 12,
    parameter logic [7:0] ID_CODE = 8'h07,
    parameter logic [7:0] ID_VER  = 8'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [1:0]      bus_size,
    input  logic [63:0]     bus_wdata,
    output logic            bus_ack,
    output logic            bus_err,
    output logic [63:0]     bus_rdata,
    output logic            evt_valid,
    input  logic            evt_ready,
    output logic [7:0]      evt_vec,
    output logic            evt_level
);
    localparam int IW    = $clog2(NSRC);
    localparam int NWORD = NSRC / 8;
    localparam int KW    = (NWORD > 1) ? $clog2(NWORD) : 1;

    typedef struct packed {
        bus_st_e                 st;
        logic                    ack;
        logic                    err;
        logic [63:0]             rdata;
        logic [NSRC-1:0]         src;
        logic [NSRC-1:0]         req_r;
        logic [NSRC-1:0]         insvc;
        logic [NSRC-1:0]         mask;
        logic [NSRC-1:0]         edge_sel;
        logic [NSRC-1:0]         pol;
        logic [NSRC-1:0]         pa;
        logic [NSRC-1:0]         pd;
        logic [NSRC-1:0][7:0]    vec;
    } st_t;

    function automatic st_t rst_state();
        st_t r;
        r      = '0;
        r.mask = '1;
        for (int i = 0; i < NSRC; i++) r.vec[i] = 8'(i);
        return r;
    endfunction

    st_t s_q, s_d;

    // lane alignment
    logic [63:0] wmask, wsh;
    logic        misal;
    logic [2:0]  off;
    logic [AW-1:0] waddr;

    assign off   = bus_addr[2:0];
    assign waddr = {bus_addr[AW-1:3], 3'b000};

    irq_vec_lanes #(.DW(64)) u_lanes (
        .off   (off),
        .size  (bus_size),
        .wdata (bus_wdata),
        .wmask (wmask),
        .wsh   (wsh),
        .misal (misal)
    );

    // scanner
    logic          pk_found;
    logic [IW-1:0] pk_idx;

    irq_vec_pick #(.N(NSRC), .IW(IW)) u_pick (
        .req   (s_q.pa | s_q.pd),
        .found (pk_found),
        .idx   (pk_idx)
    );

    // event slot
    logic       ev_load, ev_lvl, ev_room;
    logic [7:0] ev_vec;

    irq_vec_evtq #(.VW(8)) u_evtq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ev_load),
        .load_vec  (ev_vec),
        .load_lvl  (ev_lvl),
        .out_ready (evt_ready),
        .out_valid (evt_valid),
        .out_vec   (evt_vec),
        .out_lvl   (evt_level),
        .room      (ev_room)
    );

    logic busy;
    assign busy = (|s_q.pa) | (|s_q.pd) | evt_valid;

    // decode
    logic          is_id, is_mask, is_edge, is_eclr, is_pol;
    logic          mapped, vec_hit;
    logic [KW-1:0] vec_k;
    logic [63:0]   rd_word;
    logic [63:0]   id_word;
    logic          acc_err;

    assign id_word = {8'h00, 8'(NSRC - 1), 8'h00, ID_VER, ID_CODE, 24'h000000};
    assign is_id   = (waddr == AW'(ADR_ID));
    assign is_mask = (waddr == AW'(ADR_MASK));
    assign is_edge = (waddr == AW'(ADR_EDGE));
    assign is_eclr = (waddr == AW'(ADR_ECLR));
    assign is_pol  = (waddr == AW'(ADR_POL));

    always_comb begin
        rd_word = '0;
        mapped  = 1'b0;
        vec_hit = 1'b0;
        vec_k   = '0;
        if (is_id)   begin mapped = 1'b1; rd_word = id_word;          end
        if (is_mask) begin mapped = 1'b1; rd_word = 64'(s_q.mask);     end
        if (is_edge) begin mapped = 1'b1; rd_word = 64'(s_q.edge_sel); end
        if (is_eclr) begin mapped = 1'b1; end
        if (is_pol)  begin mapped = 1'b1; rd_word = 64'(s_q.pol);      end
        if (waddr == AW'(ADR_REQ))   begin mapped = 1'b1; rd_word = 64'(s_q.req_r); end
        if (waddr == AW'(ADR_INSVC)) begin mapped = 1'b1; rd_word = 64'(s_q.insvc); end
        if (waddr == AW'(ADR_AUTO0) || waddr == AW'(ADR_AUTO1)) mapped = 1'b1;
        for (int k = 0; k < NWORD; k++) begin
            if (waddr == AW'(ADR_ROUTE + 8 * k)) begin
                mapped  = 1'b1;
                rd_word = {8{ROUTE_BYTE}};
            end
            if (waddr == AW'(ADR_VEC + 8 * k)) begin
                mapped  = 1'b1;
                vec_hit = 1'b1;
                vec_k   = KW'(k);
                for (int b = 0; b < 8; b++) rd_word[8*b +: 8] = s_q.vec[8*k + b];
            end
        end
    end

    assign acc_err = misal | !mapped | (bus_we & is_id) | (!bus_we & is_eclr);

    // merged write values
    logic [63:0]     mrg_mask, mrg_edge, mrg_pol;
    logic [NSRC-1:0] new_mask, unm_bits, msk_bits, clr_bits;
    logic [NSRC-1:0] rise, lvl_fall;

    assign mrg_mask = (64'(s_q.mask)     & ~wmask) | (wsh & wmask);
    assign mrg_edge = (64'(s_q.edge_sel) & ~wmask) | (wsh & wmask);
    assign mrg_pol  = (64'(s_q.pol)      & ~wmask) | (wsh & wmask);
    assign new_mask = mrg_mask[NSRC-1:0];
    assign unm_bits = s_q.mask & ~new_mask;
    assign msk_bits = ~s_q.mask & new_mask;
    assign clr_bits = s_q.req_r & s_q.edge_sel & wsh[NSRC-1:0] & wmask[NSRC-1:0];
    assign rise     = src_in & ~s_q.src;
    assign lvl_fall = ~src_in & s_q.src & ~s_q.edge_sel;

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        s_d.err = 1'b0;
        ev_load = 1'b0;
        ev_vec  = '0;
        ev_lvl  = 1'b0;

        // one pending source per cycle, lowest index first
        if (pk_found && ev_room) begin
            if (s_q.pa[pk_idx]) begin
                s_d.pa[pk_idx] = 1'b0;
                if (s_q.req_r[pk_idx] && !s_q.mask[pk_idx]) begin
                    s_d.insvc[pk_idx] = 1'b1;
                    ev_load = 1'b1;
                    ev_vec  = s_q.vec[pk_idx];
                    ev_lvl  = 1'b1;
                end
            end else begin
                s_d.pd[pk_idx] = 1'b0;
                if (s_q.insvc[pk_idx] && !s_q.req_r[pk_idx]) begin
                    s_d.insvc[pk_idx] = 1'b0;
                    ev_load = 1'b1;
                    ev_vec  = s_q.vec[pk_idx];
                    ev_lvl  = 1'b0;
                end
            end
        end

        // input transitions
        s_d.src   = src_in;
        s_d.req_r = (s_q.req_r | rise) & ~lvl_fall;
        s_d.pa    = s_d.pa | rise;
        s_d.pd    = s_d.pd | lvl_fall;

        // register port
        case (s_q.st)
            BUS_IDLE: begin
                if (bus_req && !s_q.ack && !busy) begin
                    if (acc_err) begin
                        s_d.ack   = 1'b1;
                        s_d.err   = 1'b1;
                        s_d.rdata = '0;
                    end else if (!bus_we) begin
                        s_d.ack   = 1'b1;
                        s_d.rdata = rd_word >> {off, 3'b000};
                    end else begin
                        s_d.rdata = '0;
                        s_d.ack   = 1'b1;
                        if (is_mask) begin
                            s_d.mask = new_mask;
                            s_d.pa   = s_d.pa | unm_bits;
                            s_d.pd   = s_d.pd | msk_bits;
                            if (|(unm_bits | msk_bits)) begin
                                s_d.ack = 1'b0;
                                s_d.st  = BUS_DRAIN;
                            end
                        end
                        if (is_edge) s_d.edge_sel = mrg_edge[NSRC-1:0];
                        if (is_pol)  s_d.pol      = mrg_pol[NSRC-1:0];
                        if (is_eclr) begin
                            s_d.req_r = s_d.req_r & ~clr_bits;
                            s_d.pd    = s_d.pd | clr_bits;
                            if (|clr_bits) begin
                                s_d.ack = 1'b0;
                                s_d.st  = BUS_DRAIN;
                            end
                        end
                        if (vec_hit) begin
                            for (int b = 0; b < 8; b++) begin
                                if (wmask[8*b]) s_d.vec[int'(vec_k) * 8 + b] = wsh[8*b +: 8];
                            end
                        end
                    end
                end
            end
            default: begin
                if (!busy) begin
                    s_d.ack = 1'b1;
                    s_d.st  = BUS_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= rst_state();
        else        s_q <= s_d;
    end

    assign bus_ack   = s_q.ack;
    assign bus_err   = s_q.err;
    assign bus_rdata = s_q.rdata;

    // R12
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R12
    drain_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(!busy));

    // R9
    err_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    // R9
    err_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $stable(s_q.mask));

    // R7
    insvc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.insvc ^ $past(s_q.insvc)) <= 1);

endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    localparam int CLK_NS = 10;
    localparam int NSRC   = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_in = '0;
    logic            bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [1:0]      bus_size = '0;
    logic [63:0]     bus_wdata = '0;
    logic            bus_ack, bus_err;
    logic [63:0]     bus_rdata;
    logic            evt_valid, evt_level;
    logic            evt_ready = 1'b1;
    logic [7:0]      evt_vec;

    always #(CLK_NS / 2) clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata),
        .evt_valid (evt_valid),
        .evt_ready (evt_ready),
        .evt_vec   (evt_vec),
        .evt_level (evt_level)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    logic stall_en = 1'b0;

    typedef struct {
        logic [7:0] v;
        logic       l;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t mon_e;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_evt(input logic [7:0] v, input logic l, input string tag);
        exp_t e;
        e.v = v; e.l = l; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && evt_valid && evt_ready) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R7 unexpected event actual=%h expected=none", {evt_level, evt_vec});
                end else begin
                    mon_e = exp_q.pop_front();
                    chk(mon_e.tag, {55'b0, evt_level, evt_vec}, {55'b0, mon_e.l, mon_e.v});
                end
            end
        end
    end

    // downstream ready, changed well after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (stall_en) evt_ready = ~evt_ready;
            else          evt_ready = 1'b1;
        end
    end

    task automatic bus(input logic we, input logic [11:0] a, input logic [1:0] sz,
                       input logic [63:0] wd, output logic [63:0] rd, output logic er);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = wd;
        do @(negedge clk); while (!bus_ack);
        rd = bus_rdata;
        er = bus_err;
        bus_req = 1'b0;
        bus_we  = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [1:0] sz,
                          input logic [63:0] exp, input string tag);
        logic [63:0] rd;
        logic        er;
        bus(1'b0, a, sz, '0, rd, er);
        chk({tag, " err"}, {63'b0, er}, 64'd0);
        chk(tag, rd, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [63:0] d,
                      input logic exp_err, input string tag);
        logic [63:0] rd;
        logic        er;
        bus(1'b1, a, sz, d, rd, er);
        chk(tag, {63'b0, er}, {63'b0, exp_err});
    endtask

    task automatic rd_err(input logic [11:0] a, input logic [1:0] sz, input string tag);
        logic [63:0] rd;
        logic        er;
        bus(1'b0, a, sz, '0, rd, er);
        chk(tag, {63'b0, er}, 64'd1);
    endtask

    task automatic settle();
        repeat (200) @(negedge clk);
        chk("R7 all expected events seen", 64'(exp_q.size()), 64'd0);
    endtask

    logic [63:0] id_exp;
    logic [63:0] mask_exp;

    initial begin
        id_exp = {8'h00, 8'd63, 8'h00, 8'h01, 8'h07, 24'h000000};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 no event after reset", {63'b0, evt_valid}, 64'd0);
        rd_chk(12'h008, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R1 mask reset");
        rd_chk(12'h028, 2'd3, 64'd0, "R1 request reset");
        rd_chk(12'h030, 2'd3, 64'd0, "R1 in-service reset");
        rd_chk(12'h010, 2'd3, 64'd0, "R1 edge reset");
        rd_chk(12'h200, 2'd3, 64'h0706_0504_0302_0100, "R1 vector reset");
        rd_chk(12'h238, 2'd3, 64'h3F3E_3D3C_3B3A_3938, "R1 vector reset top");
        rd_chk(12'h100, 2'd3, 64'h0101_0101_0101_0101, "R1 route reset");

        // R11 identification
        rd_chk(12'h000, 2'd3, id_exp, "R11 id word");
        rd_chk(12'h003, 2'd0, id_exp >> 24, "R11 id byte read shifted");

        // R8 byte lanes
        wr(12'h008, 2'd0, 64'h00, 1'b0, "R8 byte write");
        rd_chk(12'h008, 2'd3, 64'hFFFF_FFFF_FFFF_FF00, "R8 byte lane only");
        wr(12'h00A, 2'd1, 64'h0000, 1'b0, "R8 half write");
        mask_exp = 64'hFFFF_FFFF_0000_FF00;
        rd_chk(12'h008, 2'd3, mask_exp, "R8 half lanes only");

        // R2 / R3 level source
        expect_evt(8'd3, 1'b1, "R2 set event src3");
        @(negedge clk); src_in[3] = 1'b1;
        settle();
        rd_chk(12'h028, 2'd3, 64'h8, "R2 request bit");
        rd_chk(12'h030, 2'd3, 64'h8, "R2 in-service bit");
        expect_evt(8'd3, 1'b0, "R3 clear event src3");
        @(negedge clk); src_in[3] = 1'b0;
        settle();
        rd_chk(12'h028, 2'd3, 64'h0, "R3 request cleared");
        rd_chk(12'h030, 2'd3, 64'h0, "R3 in-service cleared");

        // R4 / R5 edge source
        wr(12'h010, 2'd3, 64'h20, 1'b0, "R4 edge write");
        expect_evt(8'd5, 1'b1, "R4 set event src5");
        @(negedge clk); src_in[5] = 1'b1;
        settle();
        @(negedge clk); src_in[5] = 1'b0;
        settle();
        rd_chk(12'h028, 2'd3, 64'h20, "R4 request kept after fall");
        rd_chk(12'h030, 2'd3, 64'h20, "R4 in-service kept after fall");
        expect_evt(8'd5, 1'b0, "R5 clear event src5");
        wr(12'h018, 2'd3, 64'h30, 1'b0, "R5 edge-clear write");
        settle();
        rd_chk(12'h028, 2'd3, 64'h0, "R5 request cleared");
        rd_chk(12'h030, 2'd3, 64'h0, "R5 in-service cleared");

        // R13 vector remap
        wr(12'h206, 2'd0, 64'h9A, 1'b0, "R13 vector write");
        rd_chk(12'h200, 2'd3, 64'h079A_0504_0302_0100, "R13 vector lane");
        expect_evt(8'h9A, 1'b1, "R13 set event remapped");
        @(negedge clk); src_in[6] = 1'b1;
        settle();
        expect_evt(8'h9A, 1'b0, "R13 clear event remapped");
        @(negedge clk); src_in[6] = 1'b0;
        settle();

        // R7 ordering under backpressure
        stall_en = 1'b1;
        expect_evt(8'd0, 1'b1, "R7 order first");
        expect_evt(8'd1, 1'b1, "R7 order second");
        expect_evt(8'd2, 1'b1, "R7 order third");
        @(negedge clk); src_in[2:0] = 3'b111;
        settle();
        expect_evt(8'd0, 1'b0, "R7 clear order first");
        expect_evt(8'd1, 1'b0, "R7 clear order second");
        expect_evt(8'd2, 1'b0, "R7 clear order third");
        @(negedge clk); src_in[2:0] = 3'b000;
        settle();

        // R6 / R12 mask replay
        @(negedge clk); src_in[40] = 1'b1;
        settle();
        rd_chk(12'h028, 2'd3, 64'h100_0000_0000, "R6 masked request held");
        rd_chk(12'h030, 2'd3, 64'h0, "R6 masked no in-service");
        expect_evt(8'd40, 1'b1, "R6 unmask set event");
        wr(12'h00C, 2'd2, 64'hFFFF_FEFF, 1'b0, "R6 unmask write");
        chk("R12 events drained at ack", 64'(exp_q.size()), 64'd0);
        rd_chk(12'h00C, 2'd2, 64'hFFFF_FEFF, "R8 offset read shifted");
        wr(12'h00C, 2'd2, 64'hFFFF_FFFF, 1'b0, "R6 re-mask write");
        settle();
        rd_chk(12'h030, 2'd3, 64'h100_0000_0000, "R6 re-mask keeps in-service");
        expect_evt(8'd40, 1'b0, "R3 clear event after re-mask");
        @(negedge clk); src_in[40] = 1'b0;
        settle();
        stall_en = 1'b0;

        // R9 rejected accesses
        rd_err(12'h00A, 2'd2, "R9 misaligned read");
        wr(12'h009, 2'd1, 64'h0, 1'b1, "R9 misaligned write");
        rd_chk(12'h008, 2'd3, mask_exp, "R9 mask unchanged");
        rd_err(12'h050, 2'd3, "R9 unmapped read");
        wr(12'h000, 2'd3, 64'h0, 1'b1, "R9 id write");
        rd_err(12'h018, 2'd3, "R9 edge-clear read");

        // R10 ignored writes
        wr(12'h028, 2'd3, '1, 1'b0, "R10 request write accepted");
        wr(12'h030, 2'd3, '1, 1'b0, "R10 in-service write accepted");
        rd_chk(12'h028, 2'd3, 64'h0, "R10 request unchanged");
        rd_chk(12'h030, 2'd3, 64'h0, "R10 in-service unchanged");
        wr(12'h100, 2'd3, 64'h0, 1'b0, "R10 route write accepted");
        rd_chk(12'h100, 2'd3, 64'h0101_0101_0101_0101, "R10 route unchanged");
        wr(12'h038, 2'd3, '1, 1'b0, "R10 auto write accepted");
        rd_chk(12'h038, 2'd3, 64'h0, "R10 auto reads zero");

        // R14 polarity storage only
        wr(12'h020, 2'd3, 64'h1234, 1'b0, "R14 polarity write");
        rd_chk(12'h020, 2'd3, 64'h1234, "R14 polarity readback");
        expect_evt(8'd2, 1'b1, "R14 set event unaffected");
        @(negedge clk); src_in[2] = 1'b1;
        settle();
        expect_evt(8'd2, 1'b0, "R14 clear event unaffected");
        @(negedge clk); src_in[2] = 1'b0;
        settle();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule